// File: doc/BRIEF.md
# Complementary PWM Dead-Time Generator

This block turns one PWM reference per channel into a main output and an inverted output for driving the two switches of a half-bridge. Each turn-on edge is held back by a programmable number of clock cycles. The turn-off edges are not delayed. As a result, the two switches are never on together, and each one is off for the dead time before the other turns on. When a reference pulse is no longer than the dead time, that pulse is swallowed: the output it would have driven stays inactive for the whole pulse.

A single dead-time count is shared by every channel that has an output pair. A parameter mask names the channels that have only a main output; those channels pass the reference through with no delay. Three gates decide whether a channel drives a pair: its main enable, its inverted enable, and a master output enable. A break request or a clock-failure event forces every output at once to per-output idle levels and clears the master enable. The master enable then stays cleared until it is set again.

Top module: `dtg_cpwm_top`

## Requirements
- R1: While reset is held and after it is released, `moe_o` is 0 and every output shows its idle level.
- R2: At a clock edge where `brk_i` or `clk_fail_i` is high, `moe_o` becomes 0, and this wins over `moe_set_i`. At an edge where `moe_set_i` is high and neither break source is high, `moe_o` becomes 1. Otherwise `moe_o` holds its value.
- R3: Whenever `brk_i` or `clk_fail_i` is high, or `moe_o` is 0, `out_p_o` equals `idle_main_i` in the same cycle, with no clock edge needed. This holds regardless of the reference or the enables.
- R4: Under the idle override, `out_n_o` equals `idle_comp_i & ~idle_main_i`. When both idle levels of a channel are 1, the inverted output is therefore forced to 0.
- R5: Take a paired channel with both enables set and `moe_o` = 1, and a reference rise sampled at edge k. Its inverted output is 0 right after edge k. Its main output goes to 1 after edge k+D, where D is `dt_cfg_i`, provided the reference is still high then.
- R6: In the same setup, a reference fall sampled at edge k sets the main output to 0 right after edge k. The inverted output goes to 1 after edge k+D, provided the reference is still low then.
- R7: With D = 0, a paired channel with both enables set gives plain complementary outputs. After each edge, the main output equals the reference sampled at that edge and the inverted output equals its inverse.
- R8: A high pulse of W cycles with W <= D leaves the main output at 0 throughout. A pulse with W > D shows the main output high for W-D cycles. Low pulses act on the inverted output in the same way.
- R9: On a paired channel, main enable alone gives main = sampled reference and inverted = 0. Inverted enable alone gives inverted = NOT sampled reference and main = 0. Neither enable gives 0 on both outputs.
- R10: All paired channels apply the same `dt_cfg_i`, so identical references give identical output pairs.
- R11: On a channel whose `PAIR_MASK` bit is 0 (channel 3 by default), the inverted output is 0 outside the idle override. The main output equals the sampled reference when the main enable is set, with no dead time.
- R12: No channel ever has its main and inverted outputs at 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_i | input | NCH | PWM reference per channel |
| main_en_i | input | NCH | Main output enable per channel |
| comp_en_i | input | NCH | Inverted output enable per channel |
| dt_cfg_i | input | DTW | Shared dead time in clock cycles |
| idle_main_i | input | NCH | Idle level of each main output |
| idle_comp_i | input | NCH | Idle level of each inverted output |
| brk_i | input | 1 | External break request |
| clk_fail_i | input | 1 | Clock-failure break request |
| moe_set_i | input | 1 | Sets the master output enable |
| out_p_o | output | NCH | Main outputs |
| out_n_o | output | NCH | Inverted outputs |
| moe_o | output | 1 | Master output enable state |

## Verification
The bench builds the block with its default parameters: four channels, an 8-bit dead-time field, and a pair mask that leaves channel 3 without an inverted output. Channels 0 and 1 get the same reference, so the shared dead time can be compared between them. Channel 3 gets that reference too, so its undelayed, single-output behaviour shows on the same steps. Running with a dead time of 3 brings into reach swallowed pulses of width equal to D, a pulse just one cycle longer than D, and the delay on both edges. A later switch to a dead time of 0 covers the plain complementary case.

// File: rtl/dtg_pkg.sv
package dtg_pkg;

    // Default widths for the generator
    localparam int DTG_CH_DEF  = 4;
    localparam int DTG_DTW_DEF = 8;

    // Drive values for one output pair
    typedef struct packed {
        logic p;
        logic n;
    } drv_pair_t;

    // Channel mode from {main enable, inverted enable}
    typedef enum logic [1:0] {
        MODE_OFF       = 2'b00,
        MODE_COMP_ONLY = 2'b01,
        MODE_MAIN_ONLY = 2'b10,
        MODE_PAIR      = 2'b11
    } ch_mode_t;

    // Idle levels with the main output winning a conflict
    function automatic drv_pair_t idle_pair(input logic lvl_main, input logic lvl_comp);
        drv_pair_t r;
        r.p = lvl_main;
        r.n = lvl_comp & ~lvl_main;
        return r;
    endfunction

endpackage

// File: rtl/dtg_moe_ctrl.sv
module dtg_moe_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic brk_i,
    input  logic clk_fail_i,
    input  logic moe_set_i,
    output logic moe_o,
    output logic forced_o
);
    logic brk_any;

    assign brk_any = brk_i | clk_fail_i;

    // Break clears the enable and dominates a set request
    always_ff @(posedge clk) begin
        if (rst) begin
            moe_o <= 1'b0;
        end else if (brk_any) begin
            moe_o <= 1'b0;
        end else if (moe_set_i) begin
            moe_o <= 1'b1;
        end
    end

    // Override reacts to a raw break in the same cycle
    assign forced_o = brk_any | ~moe_o;

endmodule

// File: rtl/dtg_delay_lane.sv
module dtg_delay_lane #(
    parameter int DTW = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           ref_i,
    input  logic [DTW-1:0] dt_i,
    output logic           ref_q_o,
    output logic           p_ok_o,
    output logic           n_ok_o
);
    logic [DTW-1:0] cnt_p;
    logic [DTW-1:0] cnt_n;
    logic           rise;
    logic           fall;

    assign rise = ref_i & ~ref_q_o;
    assign fall = ~ref_i & ref_q_o;

    // One down-counter per output, reloaded on the edge that arms it
    always_ff @(posedge clk) begin
        if (rst) begin
            ref_q_o <= 1'b0;
            cnt_p   <= '0;
            cnt_n   <= '0;
        end else begin
            ref_q_o <= ref_i;
            if (rise)
                cnt_p <= dt_i;
            else if (cnt_p != '0)
                cnt_p <= cnt_p - 1'b1;
            if (fall)
                cnt_n <= dt_i;
            else if (cnt_n != '0)
                cnt_n <= cnt_n - 1'b1;
        end
    end

    // An output may turn on only once its delay has run out at the matching level
    assign p_ok_o = ref_q_o & (cnt_p == '0);
    assign n_ok_o = ~ref_q_o & (cnt_n == '0);

endmodule

// File: rtl/dtg_out_sel.sv
module dtg_out_sel
    import dtg_pkg::*;
(
    input  logic      forced_i,
    input  logic      idle_main_i,
    input  logic      idle_comp_i,
    input  ch_mode_t  mode_i,
    input  logic      ref_q_i,
    input  logic      p_ok_i,
    input  logic      n_ok_i,
    output drv_pair_t drv_o
);
    drv_pair_t run;

    always_comb begin
        unique case (mode_i)
            MODE_PAIR:      begin run.p = p_ok_i;  run.n = n_ok_i;   end
            MODE_MAIN_ONLY: begin run.p = ref_q_i; run.n = 1'b0;     end
            MODE_COMP_ONLY: begin run.p = 1'b0;    run.n = ~ref_q_i; end
            default:        begin run.p = 1'b0;    run.n = 1'b0;     end
        endcase
    end

    assign drv_o = forced_i ? idle_pair(idle_main_i, idle_comp_i) : run;

endmodule

// File: rtl/dtg_cpwm_top.sv
module dtg_cpwm_top
    import dtg_pkg::*;
#(
    parameter int                NCH       = DTG_CH_DEF,
    parameter int                DTW       = DTG_DTW_DEF,
    parameter logic [NCH-1:0]    PAIR_MASK = 4'b0111
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] ref_i,
    input  logic [NCH-1:0] main_en_i,
    input  logic [NCH-1:0] comp_en_i,
    input  logic [DTW-1:0] dt_cfg_i,
    input  logic [NCH-1:0] idle_main_i,
    input  logic [NCH-1:0] idle_comp_i,
    input  logic           brk_i,
    input  logic           clk_fail_i,
    input  logic           moe_set_i,
    output logic [NCH-1:0] out_p_o,
    output logic [NCH-1:0] out_n_o,
    output logic           moe_o
);
    logic forced;

    dtg_moe_ctrl u_moe (
        .clk        (clk),
        .rst        (rst),
        .brk_i      (brk_i),
        .clk_fail_i (clk_fail_i),
        .moe_set_i  (moe_set_i),
        .moe_o      (moe_o),
        .forced_o   (forced)
    );

    for (genvar g = 0; g < NCH; g++) begin : ch_g
        logic      ref_q;
        logic      p_ok;
        logic      n_ok;
        ch_mode_t  mode;
        drv_pair_t drv;

        if (PAIR_MASK[g]) begin : pair_g
            dtg_delay_lane #(.DTW(DTW)) u_lane (
                .clk     (clk),
                .rst     (rst),
                .ref_i   (ref_i[g]),
                .dt_i    (dt_cfg_i),
                .ref_q_o (ref_q),
                .p_ok_o  (p_ok),
                .n_ok_o  (n_ok)
            );
            assign mode = ch_mode_t'({main_en_i[g], comp_en_i[g]});
        end else begin : single_g
            // No inverted output: plain registered reference, no delay
            always_ff @(posedge clk) begin
                if (rst) ref_q <= 1'b0;
                else     ref_q <= ref_i[g];
            end
            assign p_ok = ref_q;
            assign n_ok = 1'b0;
            assign mode = ch_mode_t'({main_en_i[g], 1'b0});
        end

        dtg_out_sel u_sel (
            .forced_i    (forced),
            .idle_main_i (idle_main_i[g]),
            .idle_comp_i (idle_comp_i[g] & PAIR_MASK[g]),
            .mode_i      (mode),
            .ref_q_i     (ref_q),
            .p_ok_i      (p_ok),
            .n_ok_i      (n_ok),
            .drv_o       (drv)
        );

        assign out_p_o[g] = drv.p;
        assign out_n_o[g] = drv.n;
    end

endmodule

// File: rtl/dtg_cpwm_chk.sv
module dtg_cpwm_chk #(
    parameter int             NCH       = 4,
    parameter logic [NCH-1:0] PAIR_MASK = 4'b0111
) (
    input logic           clk,
    input logic           rst,
    input logic [NCH-1:0] comp_en_i,
    input logic [NCH-1:0] idle_main_i,
    input logic [NCH-1:0] idle_comp_i,
    input logic           brk_i,
    input logic           clk_fail_i,
    input logic           moe_set_i,
    input logic [NCH-1:0] out_p_o,
    input logic [NCH-1:0] out_n_o,
    input logic           moe_o
);
    logic ovr;
    assign ovr = brk_i | clk_fail_i | ~moe_o;

    assert_no_overlap_R12: assert property (@(posedge clk) disable iff (rst)
        (out_p_o & out_n_o) == '0);

    assert_break_clears_R2: assert property (@(posedge clk) disable iff (rst)
        (brk_i || clk_fail_i) |=> !moe_o);

    assert_set_moe_R2: assert property (@(posedge clk) disable iff (rst)
        (moe_set_i && !brk_i && !clk_fail_i) |=> moe_o);

    assert_idle_main_R3: assert property (@(posedge clk) disable iff (rst)
        ovr |-> (out_p_o == idle_main_i));

    for (genvar g = 0; g < NCH; g++) begin : a_g
        if (PAIR_MASK[g]) begin : pr_g
            assert_idle_comp_R4: assert property (@(posedge clk) disable iff (rst)
                ovr |-> (out_n_o[g] == (idle_comp_i[g] & ~idle_main_i[g])));
            assert_comp_gate_R9: assert property (@(posedge clk) disable iff (rst)
                (!ovr && !comp_en_i[g]) |-> !out_n_o[g]);
        end else begin : sg_g
            assert_single_out_R11: assert property (@(posedge clk) disable iff (rst)
                !ovr |-> !out_n_o[g]);
        end
    end

endmodule

bind dtg_cpwm_top dtg_cpwm_chk #(.NCH(NCH), .PAIR_MASK(PAIR_MASK)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .comp_en_i   (comp_en_i),
    .idle_main_i (idle_main_i),
    .idle_comp_i (idle_comp_i),
    .brk_i       (brk_i),
    .clk_fail_i  (clk_fail_i),
    .moe_set_i   (moe_set_i),
    .out_p_o     (out_p_o),
    .out_n_o     (out_n_o),
    .moe_o       (moe_o)
);

// File: tb/dtg_cpwm_top_tb_top.sv
`timescale 1ns/100ps
module dtg_cpwm_top_tb_top;
    localparam int NCH = 4;
    localparam int DTW = 8;
    localparam int NV  = 22;

    // {ref, expected main, expected inverted} for ch0/ch1 with D = 3
    localparam logic [2:0] VEC [NV] = '{
        3'b100, 3'b100, 3'b100, 3'b110, 3'b110,
        3'b000, 3'b000, 3'b000, 3'b001,
        3'b100, 3'b100, 3'b100,
        3'b000, 3'b000, 3'b000, 3'b001, 3'b001,
        3'b100, 3'b100, 3'b100, 3'b110, 3'b000
    };

    logic           clk = 1'b0;
    logic           rst;
    logic [NCH-1:0] ref_i, main_en, comp_en, idle_m, idle_c;
    logic [DTW-1:0] dt_cfg;
    logic           brk, clk_fail, moe_set;
    logic [NCH-1:0] out_p, out_n;
    logic           moe;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    dtg_cpwm_top dut_i (
        .clk (clk), .rst (rst), .ref_i (ref_i),
        .main_en_i (main_en), .comp_en_i (comp_en), .dt_cfg_i (dt_cfg),
        .idle_main_i (idle_m), .idle_comp_i (idle_c),
        .brk_i (brk), .clk_fail_i (clk_fail), .moe_set_i (moe_set),
        .out_p_o (out_p), .out_n_o (out_n), .moe_o (moe)
    );

    task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; ref_i = '0; main_en = '0; comp_en = '0;
        idle_m = 4'b0101; idle_c = 4'b0011; dt_cfg = 8'd3;
        brk = 1'b0; clk_fail = 1'b0; moe_set = 1'b0;
        repeat (3) tick();
        rst = 1'b0;
        tick();
        // R1 / R4: idle levels after reset, ch0 both idle high -> inverted 0
        chk("R1 moe after reset", {3'b0, moe}, 4'h0);
        chk("R1 main idle", out_p, 4'b0101);
        chk("R4 inverted idle", out_n, 4'b0010);

        moe_set = 1'b1;
        tick();
        moe_set = 1'b0;
        chk("R2 moe set", {3'b0, moe}, 4'h1);

        main_en = 4'b1111; comp_en = 4'b1111;
        repeat (4) tick();
        chk("R6 steady low ch0 main", {3'b0, out_p[0]}, 4'h0);
        chk("R6 steady low ch0 inv", {3'b0, out_n[0]}, 4'h1);

        // Table walk: ch0, ch1 and ch3 share the reference, ch2 stays low
        for (int i = 0; i < NV; i++) begin
            ref_i = {VEC[i][2], 1'b0, VEC[i][2], VEC[i][2]};
            tick();
            chk($sformatf("R5/R6/R8 ch0 main step %0d", i), {3'b0, out_p[0]}, {3'b0, VEC[i][1]});
            chk($sformatf("R5/R6/R8 ch0 inv step %0d", i),  {3'b0, out_n[0]}, {3'b0, VEC[i][0]});
            chk($sformatf("R10 ch1 pair step %0d", i), {2'b0, out_p[1], out_n[1]}, {2'b0, VEC[i][1:0]});
            chk($sformatf("R11 ch3 step %0d", i), {2'b0, out_p[3], out_n[3]}, {2'b0, VEC[i][2], 1'b0});
        end

        // Break: immediate override, then enable cleared and held
        brk = 1'b1;
        #1;
        chk("R3 break immediate main", out_p, 4'b0101);
        chk("R4 break immediate inv", out_n, 4'b0010);
        tick();
        chk("R2 break clears moe", {3'b0, moe}, 4'h0);
        brk = 1'b0;
        ref_i = 4'b1111;
        tick();
        chk("R3 latched idle main", out_p, 4'b0101);
        chk("R2 moe stays cleared", {3'b0, moe}, 4'h0);

        brk = 1'b1; moe_set = 1'b1;
        tick();
        chk("R2 break wins over set", {3'b0, moe}, 4'h0);
        brk = 1'b0;
        tick();
        moe_set = 1'b0;
        chk("R2 set after break", {3'b0, moe}, 4'h1);

        clk_fail = 1'b1;
        tick();
        clk_fail = 1'b0;
        chk("R2 clock fail clears moe", {3'b0, moe}, 4'h0);
        moe_set = 1'b1;
        tick();
        moe_set = 1'b0;

        // Zero dead time: plain complementary outputs
        dt_cfg = 8'd0;
        ref_i = '0;
        repeat (2) tick();
        ref_i[0] = 1'b1;
        tick();
        chk("R7 D0 rise", {2'b0, out_p[0], out_n[0]}, 4'b0010);
        ref_i[0] = 1'b0;
        tick();
        chk("R7 D0 fall", {2'b0, out_p[0], out_n[0]}, 4'b0001);

        // Single-enable modes on ch0
        main_en = 4'b0001; comp_en = 4'b0000;
        ref_i[0] = 1'b1;
        tick();
        chk("R9 main only high", {2'b0, out_p[0], out_n[0]}, 4'b0010);
        ref_i[0] = 1'b0;
        tick();
        chk("R9 main only low", {2'b0, out_p[0], out_n[0]}, 4'b0000);
        main_en = 4'b0000; comp_en = 4'b0001;
        tick();
        chk("R9 inverted only low", {2'b0, out_p[0], out_n[0]}, 4'b0001);
        ref_i[0] = 1'b1;
        tick();
        chk("R9 inverted only high", {2'b0, out_p[0], out_n[0]}, 4'b0000);
        comp_en = 4'b0000;
        ref_i[0] = 1'b0;
        tick();
        chk("R9 both disabled", {2'b0, out_p[0], out_n[0]}, 4'b0000);
        chk("R12 no overlap", out_p & out_n, 4'b0000);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule